// File: doc/BRIEF.md
# Wide-word banked dual-port memory

This block stores `DEPTH` user words of `USER_W` bits and gives two views of them. The user port reads and writes a whole wide word at a time, selected by a word index. The register port is one bus word wide (`BUS_W` bits). Through it, software-style logic reads and writes the same storage one slice at a time. Inside, each wide word is cut into `N_BANKS = ceil(USER_W / BUS_W)` slices, and each slice lives in its own bank.

On the register port, each bank owns a contiguous window of `DEPTH` addresses. The windows sit back to back starting at `BASE_ADDR`, so slice `i` of word `a` appears at `BASE_ADDR + a + i*DEPTH`. When `USER_W` is not a multiple of `BUS_W`, the highest bank is narrower than the bus word.

Both ports accept a request in every cycle and never stall the requester, so there is no back-pressure on either side. A read is a plain address that is held or changed in each cycle, and its data follows a fixed two-cycle latency. A write is a single-cycle strobe.

Top module: `wbm_top`

## Requirements
- R1: Slice 0 of a user word is bits [BUS_W-1:0], slice i is bits starting at i*BUS_W, and the top slice holds the remaining USER_W-(N_BANKS-1)*BUS_W most significant bits.
- R2: A register-port write to address BASE_ADDR + a + i*DEPTH updates slice i of user word a and no other slice or word.
- R3: The user read data shows the word at `usr_addr` two rising clock edges after the address is applied; after only one edge it still shows the previous result.
- R4: Register-port read data for an in-range address appears two rising edges after the address is applied. A narrow top slice is returned zero-extended in the upper bits.
- R5: A register-port write to the top bank stores only that bank's valid low bits and discards the rest of the bus word.
- R6: A user-port write updates all N_BANKS slices, so that register-port reads of every slice window return the matching slice of the written word.
- R7: Slices written one by one through the register port read back on the user port as the reassembled wide word.
- R8: Register-port writes to addresses below BASE_ADDR, or at or above BASE_ADDR + N_BANKS*DEPTH, change no stored data.
- R9: Register-port reads of addresses outside that range return zero after the normal two-edge latency.
- R10: When the user port and the register port write the same bank location on the same edge, the user-port data is stored.
- R11: While reset is asserted, both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the read pipelines |
| usr_addr | input | UAW | User word index |
| usr_wr_en | input | 1 | User write strobe, one word per cycle |
| usr_wr_data | input | USER_W | User write data |
| usr_rd_data | output | USER_W | User read data, two cycles after the address |
| reg_addr | input | BUS_AW | Register-port address |
| reg_wr_en | input | 1 | Register-port write strobe |
| reg_wr_data | input | BUS_W | Register-port write data |
| reg_rd_data | output | BUS_W | Register-port read data, two cycles after the address, zero when out of range |

## Verification
The bench builds the block with USER_W=40, BUS_W=16, DEPTH=16, BASE_ADDR=0x20 and an 8-bit register address. With these values there are three banks, and the top bank is only 8 bits wide, so the truncation and zero-extension cases both occur. The whole 256-entry register address space can be swept, covering the mapped window 0x20 to 0x4F and the unmapped space on both sides of it. Every word index is written and read through both ports. Expected slices and words come from shifts and masks of arithmetic patterns.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/wbm_bank.sv
module wbm_bank #(
  parameter int W     = 16,
  parameter int BW    = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          u_we,
  input  logic [AW-1:0] u_addr,
  input  logic [W-1:0]  u_wd,
  output logic [W-1:0]  u_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wd,
  output logic [BW-1:0] b_q
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] bq_r;

  // read-first; the user write is issued last so it wins a collision
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    if (u_we) mem[u_addr] <= u_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_q  <= '0;
      bq_r <= '0;
    end else begin
      u_q  <= mem[u_addr];
      bq_r <= mem[b_addr];
    end
  end

  generate
    if (W < BW) begin : g_pad
      assign b_q = {{(BW-W){1'b0}}, bq_r};
    end else begin : g_full
      assign b_q = bq_r;
    end
  endgenerate

  // last user write remembered for the check below
  logic          u_we_d;
  logic [AW-1:0] u_addr_d;
  logic [W-1:0]  u_wd_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_we_d   <= 1'b0;
      u_addr_d <= '0;
      u_wd_d   <= '0;
    end else begin
      u_we_d   <= u_we;
      u_addr_d <= u_addr;
      u_wd_d   <= u_wd;
    end
  end

  AST_USER_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (u_we_d && u_addr == u_addr_d) |=> (u_q == $past(u_wd_d))); // R10
endmodule

// File: rtl/wbm_decode.sv
module wbm_decode #(
  parameter int BUS_AW    = 8,
  parameter int BASE_ADDR = 32,
  parameter int DEPTH     = 16,
  parameter int N_BANKS   = 3,
  parameter int AW        = 4,
  parameter int IDXW      = 2
) (
  input  logic [BUS_AW-1:0] addr,
  output logic              hit,
  output logic [IDXW-1:0]   bank,
  output logic [AW-1:0]     row
);
  localparam logic [31:0] LIMIT = 32'(BASE_ADDR + N_BANKS * DEPTH);
  logic [31:0] full;
  logic [31:0] off;

  always_comb begin
    full = 32'(addr);
    off  = full - 32'(BASE_ADDR);
    hit  = (full >= 32'(BASE_ADDR)) && (full < LIMIT);
    bank = IDXW'(off / 32'(DEPTH));
    row  = AW'(off % 32'(DEPTH));
  end
endmodule

// File: rtl/wbm_top.sv
module wbm_top #(
  parameter int USER_W    = 40,
  parameter int BUS_W     = 16,
  parameter int DEPTH     = 16,
  parameter int BUS_AW    = 8,
  parameter int BASE_ADDR = 32,
  parameter int UAW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UAW-1:0]    usr_addr,
  input  logic              usr_wr_en,
  input  logic [USER_W-1:0] usr_wr_data,
  output logic [USER_W-1:0] usr_rd_data,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [BUS_W-1:0]  reg_wr_data,
  output logic [BUS_W-1:0]  reg_rd_data
);
  localparam int N_BANKS = wbm_pkg::ceil_div(USER_W, BUS_W);
  localparam int IDXW    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int LIMIT   = BASE_ADDR + N_BANKS * DEPTH;

  logic              hit;
  logic [IDXW-1:0]   bank_sel;
  logic [UAW-1:0]    row;
  logic [N_BANKS-1:0] bank_bwe;
  logic [USER_W-1:0] user_q;
  logic [BUS_W-1:0]  bus_q [N_BANKS];

  wbm_decode #(
    .BUS_AW(BUS_AW), .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH),
    .N_BANKS(N_BANKS), .AW(UAW), .IDXW(IDXW)
  ) u_dec (
    .addr(reg_addr), .hit(hit), .bank(bank_sel), .row(row)
  );

  generate
    for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
      localparam int SW = (i == N_BANKS - 1) ? USER_W - i * BUS_W : BUS_W;
      assign bank_bwe[i] = reg_wr_en && hit && (bank_sel == IDXW'(i));
      wbm_bank #(.W(SW), .BW(BUS_W), .DEPTH(DEPTH), .AW(UAW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .u_we(usr_wr_en), .u_addr(usr_addr),
        .u_wd(usr_wr_data[i*BUS_W +: SW]), .u_q(user_q[i*BUS_W +: SW]),
        .b_we(bank_bwe[i]), .b_addr(row),
        .b_wd(reg_wr_data[SW-1:0]), .b_q(bus_q[i])
      );
    end
  endgenerate

  logic            hit_q;
  logic [IDXW-1:0] sel_q;
  logic [BUS_W-1:0] bus_mux;

  always_comb begin
    bus_mux = '0;
    for (int i = 0; i < N_BANKS; i++)
      if (sel_q == IDXW'(i)) bus_mux = bus_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q       <= 1'b0;
      sel_q       <= '0;
      usr_rd_data <= '0;
      reg_rd_data <= '0;
    end else begin
      hit_q       <= hit;
      sel_q       <= bank_sel;
      usr_rd_data <= user_q;
      reg_rd_data <= hit_q ? bus_mux : '0;
    end
  end

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_bwe)); // R2
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (32'(reg_addr) < 32'(BASE_ADDR) || 32'(reg_addr) >= 32'(LIMIT)))
      |-> (bank_bwe == '0)); // R8
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(reg_addr) < 32'(BASE_ADDR) || 32'(reg_addr) >= 32'(LIMIT))
      |-> ##2 (reg_rd_data == '0)); // R9
endmodule

// File: tb/wbm_top_test.sv
`timescale 1ns/1ps
module wbm_top_test;
  localparam int UW = 40, BW = 16, DP = 16, AWB = 8, BASE = 32, UAW = 4;
  localparam int NB = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [UAW-1:0] usr_addr = '0;
  logic usr_wr_en = 1'b0;
  logic [UW-1:0] usr_wr_data = '0;
  logic [UW-1:0] usr_rd_data;
  logic [AWB-1:0] reg_addr = '0;
  logic reg_wr_en = 1'b0;
  logic [BW-1:0] reg_wr_data = '0;
  logic [BW-1:0] reg_rd_data;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [UW-1:0] model [DP];

  always #2.5 clk = ~clk;

  wbm_top #(.USER_W(UW), .BUS_W(BW), .DEPTH(DP), .BUS_AW(AWB), .BASE_ADDR(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_wr_en(usr_wr_en),
    .usr_wr_data(usr_wr_data), .usr_rd_data(usr_rd_data), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] bus_pat(input int a, input int i);
    return 16'((i + 1) * 16'h1357 + a * 16'h0911 + 16'h8000);
  endfunction
  function automatic logic [UW-1:0] usr_pat(input int a);
    return 40'(a * 40'h01_2345_6789 + 40'hA5_0F0F_F0F0);
  endfunction
  function automatic logic [BW-1:0] slice_of(input logic [UW-1:0] w, input int i);
    return 16'(w >> (16 * i));
  endfunction

  task automatic bus_wr(input int addr, input logic [BW-1:0] d);
    @(negedge clk);
    reg_addr = AWB'(addr); reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask
  task automatic bus_rd(input int addr, output logic [BW-1:0] d);
    @(negedge clk);
    reg_addr = AWB'(addr);
    @(negedge clk);
    @(negedge clk);
    d = reg_rd_data;
  endtask
  task automatic usr_wr(input int a, input logic [UW-1:0] d);
    @(negedge clk);
    usr_addr = UAW'(a); usr_wr_data = d; usr_wr_en = 1'b1;
    @(negedge clk);
    usr_wr_en = 1'b0;
  endtask
  task automatic usr_rd(input int a, output logic [UW-1:0] d);
    @(negedge clk);
    usr_addr = UAW'(a);
    @(negedge clk);
    @(negedge clk);
    d = usr_rd_data;
  endtask

  initial begin
    logic [BW-1:0] bd;
    logic [UW-1:0] ud;
    repeat (3) @(negedge clk);
    check("R11 usr_rd_data in reset", 64'(usr_rd_data), 64'd0);
    check("R11 reg_rd_data in reset", 64'(reg_rd_data), 64'd0);
    rst_n = 1'b1;

    // register-port writes, user-port reassembly
    for (int a = 0; a < DP; a++) begin
      for (int i = 0; i < NB; i++) bus_wr(BASE + a + i * DP, bus_pat(a, i));
      model[a] = {bus_pat(a, 2)[7:0], bus_pat(a, 1), bus_pat(a, 0)};
    end
    for (int a = 0; a < DP; a++) begin
      usr_rd(a, ud);
      check("R7 reassembled word", 64'(ud), 64'(model[a]));
      for (int i = 0; i < NB; i++) begin
        bus_rd(BASE + a + i * DP, bd);
        if (i == NB - 1) check("R5 top slice truncated", 64'(bd), 64'(slice_of(model[a], i)));
        else check("R2 slice window", 64'(bd), 64'(slice_of(model[a], i)));
      end
    end

    // user-port writes, register-port slices
    for (int a = 0; a < DP; a++) begin
      usr_wr(a, usr_pat(a));
      model[a] = usr_pat(a);
    end
    for (int a = 0; a < DP; a++)
      for (int i = 0; i < NB; i++) begin
        bus_rd(BASE + a + i * DP, bd);
        check("R1 R6 slice of user word", 64'(bd), 64'(slice_of(model[a], i)));
      end

    // latency, user side: word 3 shown, switch to word 9
    usr_rd(3, ud);
    @(negedge clk);
    usr_addr = UAW'(9);
    @(negedge clk);
    check("R3 one edge still old", 64'(usr_rd_data), 64'(model[3]));
    @(negedge clk);
    check("R3 two edges new", 64'(usr_rd_data), 64'(model[9]));

    // latency, register side (top slice zero-extended)
    bus_rd(BASE + 4, bd);
    @(negedge clk);
    reg_addr = AWB'(BASE + 11 + 2 * DP);
    @(negedge clk);
    check("R4 one edge still old", 64'(reg_rd_data), 64'(slice_of(model[4], 0)));
    @(negedge clk);
    check("R4 two edges new zero-extended", 64'(reg_rd_data), 64'(slice_of(model[11], 2)));

    // out-of-range sweep
    for (int ad = 0; ad < 256; ad++)
      if (ad < BASE || ad >= BASE + NB * DP) bus_wr(ad, 16'hFFFF);
    for (int ad = 0; ad < 256; ad++)
      if (ad < BASE || ad >= BASE + NB * DP) begin
        bus_rd(ad, bd);
        check("R9 out of range read", 64'(bd), 64'd0);
      end
    for (int a = 0; a < DP; a++) begin
      usr_rd(a, ud);
      check("R8 stored word untouched", 64'(ud), 64'(model[a]));
    end

    // same-edge collision on word 5, slice 1
    @(negedge clk);
    usr_addr = UAW'(5); usr_wr_data = 40'h12_3456_789A; usr_wr_en = 1'b1;
    reg_addr = AWB'(BASE + 5 + DP); reg_wr_data = 16'hBEEF; reg_wr_en = 1'b1;
    @(negedge clk);
    usr_wr_en = 1'b0; reg_wr_en = 1'b0;
    model[5] = 40'h12_3456_789A;
    usr_rd(5, ud);
    check("R10 user word wins", 64'(ud), 64'(model[5]));
    bus_rd(BASE + 5 + DP, bd);
    check("R10 slice holds user data", 64'(bd), 64'(slice_of(model[5], 1)));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule